// File: doc/BRIEF.md
# Burst Beat Sequencer with Latency

This block turns one already-granted transfer into a train of data beats, each no wider than the bus, and places those beats in time. The timing comes from fixed pipeline offsets that depend on the direction of the transfer, plus four programmable extra-cycle settings. Upstream logic pulses `start` with the command, the total byte count and the bus width in bytes. The block then raises a per-beat strobe with running byte accounting, flags the first and the final beat, and finally raises a single response strobe.

A read reaches the target after a four-stage request path: master port, arbitration, crossbar and slave port. One further channel cycle follows before the read data beats begin, and the master sees the data one cycle after the final beat. A write launches its first word four cycles after start and acknowledges three cycles after its final word. A byte count that is not a multiple of the width ends with a short beat. While a transfer is in progress the block holds `busy` high and drops further start pulses.

Top module: `burst_beat_seq`

## Requirements
- R1: The number of beats is the byte count divided by the bus width, rounded up. Every beat carries the bus width in bytes, except that the final beat carries whatever is left.
- R2: On each beat, `beat_sent` is the cumulative number of bytes moved, including that beat, and `beat_remaining` is the number of bytes still owed after it. For example, 100 bytes at width 4 give 4 and 96 on the first beat.
- R3: For a read (`cmd_write`=0), the first beat is visible in the cycle that follows the 5+Xrq+Xrd'th rising edge after the edge that sampled `start`. Xrq is `xtra_rd_req` and Xrd is `xtra_rd_data`. All beats occupy consecutive cycles.
- R4: For a write (`cmd_write`=1), the first beat follows the 4+Xwq+Xwd'th edge. Xwq is `xtra_wr_req` and Xwd is `xtra_wr_data`. Beats are consecutive, so 4 beats with no extras end on edge 7.
- R5: For a read, `resp_valid` pulses for one cycle, exactly one cycle after the final beat.
- R6: For a write, `resp_valid` pulses for one cycle, exactly three cycles after the final beat.
- R7: `first_word` is high only with the first beat, and `last_word` is high only with the final beat. A single-beat transfer raises both together.
- R8: `busy` rises on the edge that accepts a start and falls on the edge after the response cycle. A `start` seen while `busy` is high is ignored, and the running transfer's beats and response are unchanged.
- R9: A `start` with a total byte count of 0 or a bus width of 0 is ignored: `busy` stays low and no strobe appears.
- R10: After reset, `busy`, `beat_valid`, `first_word`, `last_word` and `resp_valid` are low.
- R11: Extra-cycle settings of the other direction have no effect: a read ignores `xtra_wr_req`/`xtra_wr_data`, and a write ignores `xtra_rd_req`/`xtra_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse for a granted transfer |
| cmd_write | input | 1 | 1 = write, 0 = read |
| total_bytes | input | BYTES_W | Total bytes of the transfer |
| bus_bytes | input | BW_W | Bus width in bytes |
| xtra_rd_req | input | EXTRA_W | Extra cycles on the read request path |
| xtra_wr_req | input | EXTRA_W | Extra cycles on the write request path |
| xtra_rd_data | input | EXTRA_W | Extra cycles on the read data path |
| xtra_wr_data | input | EXTRA_W | Extra cycles on the write data path |
| busy | output | 1 | Transfer in progress |
| beat_valid | output | 1 | A data beat is present this cycle |
| beat_sent | output | BYTES_W | Cumulative bytes including this beat |
| beat_remaining | output | BYTES_W | Bytes still owed after this beat |
| first_word | output | 1 | Marks the first beat |
| last_word | output | 1 | Marks the final beat |
| resp_valid | output | 1 | Completion strobe to the master |

## Verification
A wrong lead counter shifts every beat of a transfer, and the bench notices at the very first beat because it compares the arrival cycle as well as the value. A corrupted byte ledger shows on the next beat, either as a wrong sent/remaining pair or as a sum that no longer equals the total. A bad final-beat decision gives a missing or extra beat, which appears as a queue mismatch in the following cycle. A phase machine that leaves the tail too early or too late moves `resp_valid` and the fall of `busy`, and an accepted start while busy shows up as unexpected strobes.

// File: rtl/burst_beat_pkg.sv
package burst_beat_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LEAD  = 2'd1,
      PH_BEATS = 2'd2,
      PH_TAIL  = 2'd3
   } phase_e;

   localparam int RD_LEAD_BASE = 5;
   localparam int WR_LEAD_BASE = 4;
   localparam int RD_TAIL_LEN  = 1;
   localparam int WR_TAIL_LEN  = 3;
endpackage

// File: rtl/burst_lat_calc.sv
module burst_lat_calc
   import burst_beat_pkg::*;
#(
   parameter int EXTRA_W = 4,
   parameter bit EXTRA_EN = 1'b1,
   localparam int CNT_W = EXTRA_W + 2
) (
   input  logic               cmd_write,
   input  logic [EXTRA_W-1:0] x_rd_req,
   input  logic [EXTRA_W-1:0] x_wr_req,
   input  logic [EXTRA_W-1:0] x_rd_data,
   input  logic [EXTRA_W-1:0] x_wr_data,
   output logic [CNT_W-1:0]   lead_len,
   output logic [CNT_W-1:0]   tail_len
);
   logic [CNT_W-1:0] add_rd;
   logic [CNT_W-1:0] add_wr;

   generate
      if (EXTRA_EN) begin : g_extra
         always_comb begin
            add_rd = CNT_W'(x_rd_req) + CNT_W'(x_rd_data);
            add_wr = CNT_W'(x_wr_req) + CNT_W'(x_wr_data);
         end
      end else begin : g_fixed
         logic unused_x;
         always_comb begin
            add_rd   = '0;
            add_wr   = '0;
            unused_x = ^{x_rd_req, x_wr_req, x_rd_data, x_wr_data};
         end
      end
   endgenerate

   always_comb begin
      if (cmd_write) begin
         lead_len = CNT_W'(WR_LEAD_BASE) + add_wr;
         tail_len = CNT_W'(WR_TAIL_LEN);
      end else begin
         lead_len = CNT_W'(RD_LEAD_BASE) + add_rd;
         tail_len = CNT_W'(RD_TAIL_LEN);
      end
   end
endmodule

// File: rtl/burst_phase_ctrl.sv
module burst_phase_ctrl
   import burst_beat_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [CNT_W-1:0] lead_len,
   input  logic [CNT_W-1:0] tail_len,
   input  logic             final_beat,
   output phase_e           phase,
   output logic             tail_done
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tail_q;

   assign tail_done = (phase == PH_TAIL) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt_q  <= '0;
         tail_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (launch) begin
                  phase  <= PH_LEAD;
                  cnt_q  <= lead_len - 1'b1;
                  tail_q <= tail_len;
               end
            end
            PH_LEAD: begin
               if (cnt_q == '0) phase <= PH_BEATS;
               else             cnt_q <= cnt_q - 1'b1;
            end
            PH_BEATS: begin
               if (final_beat) begin
                  phase <= PH_TAIL;
                  cnt_q <= tail_q - 1'b1;
               end
            end
            PH_TAIL: begin
               if (cnt_q == '0) phase <= PH_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/burst_byte_ledger.sv
module burst_byte_ledger #(
   parameter int BYTES_W = 16,
   parameter int BW_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [BYTES_W-1:0] total_bytes,
   input  logic [BW_W-1:0]    bus_bytes,
   input  logic               beat_en,
   output logic [BYTES_W-1:0] sent_now,
   output logic [BYTES_W-1:0] rem_now,
   output logic               is_first,
   output logic               is_final
);
   logic [BYTES_W-1:0] rem_q;
   logic [BYTES_W-1:0] sent_q;
   logic [BYTES_W-1:0] width_q;
   logic [BYTES_W-1:0] chunk;

   always_comb begin
      chunk    = (rem_q > width_q) ? width_q : rem_q;
      sent_now = sent_q + chunk;
      rem_now  = rem_q - chunk;
      is_first = (sent_q == '0);
      is_final = (rem_q <= width_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         sent_q  <= '0;
         width_q <= '0;
      end else if (launch) begin
         rem_q   <= total_bytes;
         sent_q  <= '0;
         width_q <= BYTES_W'(bus_bytes);
      end else if (beat_en) begin
         rem_q  <= rem_now;
         sent_q <= sent_now;
      end
   end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
   import burst_beat_pkg::*;
#(
   parameter int BYTES_W = 16,
   parameter int BW_W = 8,
   parameter int EXTRA_W = 4,
   parameter bit EXTRA_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               cmd_write,
   input  logic [BYTES_W-1:0] total_bytes,
   input  logic [BW_W-1:0]    bus_bytes,
   input  logic [EXTRA_W-1:0] xtra_rd_req,
   input  logic [EXTRA_W-1:0] xtra_wr_req,
   input  logic [EXTRA_W-1:0] xtra_rd_data,
   input  logic [EXTRA_W-1:0] xtra_wr_data,
   output logic               busy,
   output logic               beat_valid,
   output logic [BYTES_W-1:0] beat_sent,
   output logic [BYTES_W-1:0] beat_remaining,
   output logic               first_word,
   output logic               last_word,
   output logic               resp_valid
);
   localparam int CNT_W = EXTRA_W + 2;

   generate
      if (BW_W > BYTES_W) begin : g_bad_bw
         $error("BW_W must not exceed BYTES_W");
      end
      if (EXTRA_W < 1 || EXTRA_W > 8) begin : g_bad_extra
         $error("EXTRA_W must be between 1 and 8");
      end
      if (BYTES_W < 2) begin : g_bad_bytes
         $error("BYTES_W must be at least 2");
      end
   endgenerate

   phase_e             phase;
   logic               launch;
   logic               tail_done;
   logic               is_first;
   logic               is_final;
   logic [CNT_W-1:0]   lead_len;
   logic [CNT_W-1:0]   tail_len;

   assign busy       = (phase != PH_IDLE);
   assign launch     = start && !busy && (total_bytes != '0) && (bus_bytes != '0);
   assign beat_valid = (phase == PH_BEATS);
   assign first_word = beat_valid && is_first;
   assign last_word  = beat_valid && is_final;
   assign resp_valid = tail_done;

   burst_lat_calc #(
      .EXTRA_W  (EXTRA_W),
      .EXTRA_EN (EXTRA_EN)
   ) u_lat (
      .cmd_write (cmd_write),
      .x_rd_req  (xtra_rd_req),
      .x_wr_req  (xtra_wr_req),
      .x_rd_data (xtra_rd_data),
      .x_wr_data (xtra_wr_data),
      .lead_len  (lead_len),
      .tail_len  (tail_len)
   );

   burst_phase_ctrl #(
      .CNT_W (CNT_W)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .lead_len   (lead_len),
      .tail_len   (tail_len),
      .final_beat (last_word),
      .phase      (phase),
      .tail_done  (tail_done)
   );

   burst_byte_ledger #(
      .BYTES_W (BYTES_W),
      .BW_W    (BW_W)
   ) u_ledger (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .total_bytes (total_bytes),
      .bus_bytes   (bus_bytes),
      .beat_en     (beat_valid),
      .sent_now    (beat_sent),
      .rem_now     (beat_remaining),
      .is_first    (is_first),
      .is_final    (is_final)
   );
endmodule

// File: rtl/burst_beat_seq_chk.sv
module burst_beat_seq_chk #(
   parameter int BYTES_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               beat_valid,
   input logic [BYTES_W-1:0] beat_sent,
   input logic [BYTES_W-1:0] beat_remaining,
   input logic               first_word,
   input logic               last_word,
   input logic               resp_valid
);
   logic [BYTES_W:0] total_now;
   assign total_now = {1'b0, beat_sent} + {1'b0, beat_remaining};

   p_first_in_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      first_word |-> beat_valid);

   p_last_ends_train_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last_word |=> !beat_valid);

   p_beats_contiguous_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !last_word) |=> (beat_valid && !first_word));

   p_bytes_conserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !first_word) |-> (total_now == $past(total_now)));

   p_remaining_falls_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !first_word) |-> (beat_remaining < $past(beat_remaining)));

   p_final_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
      last_word |-> (beat_remaining == '0));

   p_resp_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !busy);

   p_strobes_need_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid || resp_valid) |-> busy);
endmodule

bind burst_beat_seq burst_beat_seq_chk #(
   .BYTES_W (BYTES_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy           (busy),
   .beat_valid     (beat_valid),
   .beat_sent      (beat_sent),
   .beat_remaining (beat_remaining),
   .first_word     (first_word),
   .last_word      (last_word),
   .resp_valid     (resp_valid)
);

// File: tb/burst_beat_seq_bench.sv
`timescale 1ns/1ps
module burst_beat_seq_bench;
   localparam int BYTES_W = 16;
   localparam int BW_W    = 8;
   localparam int EXTRA_W = 4;

   typedef struct {
      int    cyc;
      bit    resp;
      int    sent;
      int    rem;
      bit    first;
      bit    last;
      string req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cmd_write = 1'b0;
   logic [BYTES_W-1:0] total_bytes = '0;
   logic [BW_W-1:0]    bus_bytes = '0;
   logic [EXTRA_W-1:0] xtra_rd_req = '0;
   logic [EXTRA_W-1:0] xtra_wr_req = '0;
   logic [EXTRA_W-1:0] xtra_rd_data = '0;
   logic [EXTRA_W-1:0] xtra_wr_data = '0;
   logic               busy;
   logic               beat_valid;
   logic [BYTES_W-1:0] beat_sent;
   logic [BYTES_W-1:0] beat_remaining;
   logic               first_word;
   logic               last_word;
   logic               resp_valid;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   burst_beat_seq #(
      .BYTES_W (BYTES_W),
      .BW_W    (BW_W),
      .EXTRA_W (EXTRA_W)
   ) u_burst_beat_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (start),
      .cmd_write      (cmd_write),
      .total_bytes    (total_bytes),
      .bus_bytes      (bus_bytes),
      .xtra_rd_req    (xtra_rd_req),
      .xtra_wr_req    (xtra_wr_req),
      .xtra_rd_data   (xtra_rd_data),
      .xtra_wr_data   (xtra_wr_data),
      .busy           (busy),
      .beat_valid     (beat_valid),
      .beat_sent      (beat_sent),
      .beat_remaining (beat_remaining),
      .first_word     (first_word),
      .last_word      (last_word),
      .resp_valid     (resp_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor: pop and compare each strobe as it appears
   always @(negedge clk) begin
      if (rst_n && (beat_valid || resp_valid)) begin
         if (q.size() == 0) begin
            check(1'b0, "R8", "unexpected strobe at cycle", cyc, -1);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(cyc == e.cyc, e.req, "strobe cycle", cyc, e.cyc);
            check(resp_valid == e.resp, e.req, "resp_valid", int'(resp_valid), int'(e.resp));
            check(beat_valid == !e.resp, e.req, "beat_valid", int'(beat_valid), int'(!e.resp));
            if (!e.resp) begin
               check(int'(beat_sent) == e.sent, "R2", "beat_sent", int'(beat_sent), e.sent);
               check(int'(beat_remaining) == e.rem, "R2", "beat_remaining",
                     int'(beat_remaining), e.rem);
               check(first_word == e.first, "R7", "first_word", int'(first_word), int'(e.first));
               check(last_word == e.last, "R7", "last_word", int'(last_word), int'(e.last));
            end
         end
      end
   end

   // driver: compute expected beats and response, then pulse start
   task automatic launch(input bit wr, input int tot, input int bw,
                         input int xrq, input int xwq, input int xrd, input int xwd,
                         input string treq);
      int lead;
      int t0;
      int left;
      int sent;
      int k;
      exp_t e;
      lead = wr ? (4 + xwq + xwd) : (5 + xrq + xrd);
      t0   = cyc + 1;
      left = tot;
      sent = 0;
      k    = 0;
      while (left > 0) begin
         int ch;
         ch     = (left > bw) ? bw : left;
         sent  += ch;
         left  -= ch;
         e.cyc   = t0 + lead + k;
         e.resp  = 1'b0;
         e.sent  = sent;
         e.rem   = left;
         e.first = (k == 0);
         e.last  = (left == 0);
         e.req   = (k == 0) ? treq : "R1";
         q.push_back(e);
         k++;
      end
      e.cyc  = t0 + lead + k - 1 + (wr ? 3 : 1);
      e.resp = 1'b1;
      e.req  = wr ? "R6" : "R5";
      q.push_back(e);
      cmd_write    = wr;
      total_bytes  = BYTES_W'(tot);
      bus_bytes    = BW_W'(bw);
      xtra_rd_req  = EXTRA_W'(xrq);
      xtra_wr_req  = EXTRA_W'(xwq);
      xtra_rd_data = EXTRA_W'(xrd);
      xtra_wr_data = EXTRA_W'(xwd);
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
   endtask

   task automatic drain(input int resp_cyc);
      while (busy) begin
         @(negedge clk);
      end
      check(cyc == resp_cyc + 1, "R8", "busy fall cycle", cyc, resp_cyc + 1);
      check(q.size() == 0, "R1", "items left in queue", q.size(), 0);
   endtask

   task automatic run(input bit wr, input int tot, input int bw,
                      input int xrq, input int xwq, input int xrd, input int xwd,
                      input string treq);
      int resp_at;
      launch(wr, tot, bw, xrq, xwq, xrd, xwd, treq);
      resp_at = q[q.size()-1].cyc;
      drain(resp_at);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(busy == 1'b0, "R10", "busy in reset", int'(busy), 0);
      check(beat_valid == 1'b0, "R10", "beat_valid in reset", int'(beat_valid), 0);
      check(resp_valid == 1'b0, "R10", "resp_valid in reset", int'(resp_valid), 0);
      check((first_word | last_word) == 1'b0, "R10", "first/last in reset",
            int'(first_word | last_word), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 read 32 bytes on 8-byte bus, no extras
      run(1'b0, 32, 8, 0, 0, 0, 0, "R3");
      // R4 write 32 bytes on 8-byte bus, first word at 4, last at 7
      run(1'b1, 32, 8, 0, 0, 0, 0, "R4");
      // R2/R11 read 100 on 4-byte bus, read extras used, write extras ignored
      run(1'b0, 100, 4, 2, 7, 1, 9, "R11");
      // R1/R11 write 10 on 4-byte bus: short final beat, read extras ignored
      run(1'b1, 10, 4, 5, 3, 6, 2, "R11");
      // R7 single beat: width larger than byte count
      run(1'b1, 3, 8, 0, 0, 0, 0, "R7");
      // R1 large transfer with maximum extras
      run(1'b0, 1000, 255, 15, 0, 15, 0, "R3");

      // R8: start during busy is ignored
      begin
         int resp_at;
         launch(1'b0, 24, 8, 1, 0, 0, 0, "R8");
         resp_at = q[q.size()-1].cyc;
         repeat (2) @(negedge clk);
         cmd_write   = 1'b1;
         total_bytes = 16'd64;
         bus_bytes   = 8'd2;
         start       = 1'b1;
         @(negedge clk);
         start = 1'b0;
         drain(resp_at);
         repeat (6) @(negedge clk);
         check(busy == 1'b0, "R8", "busy after ignored start", int'(busy), 0);
      end

      // R9: zero byte count and zero width ignored
      total_bytes = '0;
      bus_bytes   = 8'd4;
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R9", "busy after zero-byte start", int'(busy), 0);
      total_bytes = 16'd16;
      bus_bytes   = '0;
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R9", "busy after zero-width start", int'(busy), 0);
      repeat (12) @(negedge clk);
      check(q.size() == 0, "R9", "queue after ignored starts", q.size(), 0);

      done = 1'b1;
   end

   initial begin
      int waited;
      waited = 0;
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R8 watchdog expired: actual %0d expected %0d", waited, 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule